// File: doc/BRIEF.md
# Programmable Countdown Timer with Interrupt

This block is an 8-bit down-counter driven by one of four prescaled tick rates, derived inside the block from a 32768 Hz reference enable. Software sets it up through a 5-bit control register and a data register. The control register holds a run bit, a 2-bit source select, an interrupt enable and an interrupt mode bit. The data register holds the countdown value. While the block runs, each tick of the selected source lowers the count by one. When a period is complete, the block sets a sticky flag and reloads the count.

The interrupt output has two behaviours. In level mode it follows the flag. In pulse mode it is high for a fixed number of system clocks at each expiry, whatever the state of the flag. Reading the data port gives the live count. The block runs on a single system clock. All ticks are one-cycle enables, and no derived clock is used.

Top module: `cdt_top`

## Requirements
- R1: After reset, ctl_rdata is 5'b00110, which selects the slowest source with run, interrupt enable and pulse mode all 0. After reset cnt_rdata is 0 and flag and irq are 0.
- R2: The control field layout is: bit0 run, bits 2:1 source, bit3 interrupt enable, bit4 pulse mode. The source codes are 00 for 4096 Hz (one tick every 2^DIV_FAST reference enables), 01 for 64 Hz (every 2^DIV_MID), 10 for 1 Hz (every 2^DIV_SLOW) and 11 for once per minute (every MIN_TICKS 1 Hz ticks). A control write shows on ctl_rdata in the next cycle.
- R3: A write on the data port sets the reload value and the live count, visible on cnt_rdata in the next cycle. A write takes priority over a tick that arrives in the same cycle.
- R4: While run is 1, the count drops by one on each tick of the selected source, and ticks of the other sources have no effect. While run is 0, the count holds.
- R5: With a loaded value N greater than 0, the tick that finds the count at 1 reloads the count to N and sets the flag in the same cycle. The count therefore goes N, N-1, ..., 1, N.
- R6: With a loaded value of 0, the count stays at 0 and the flag is never set.
- R7: The flag stays set until a flag_clr pulse clears it. If an expiry and a clear arrive in the same cycle, the expiry wins.
- R8: With interrupt enable 1 and pulse mode 0, irq equals flag.
- R9: With interrupt enable 1 and pulse mode 1, irq is high for PULSE_LEN cycles. The pulse starts in the cycle after each expiry, and it starts whether or not the flag is still set.
- R10: With interrupt enable 0, irq stays low even while the flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle enable at the 32768 Hz reference rate |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Control write data |
| ctl_rdata | output | 5 | Control register contents |
| cnt_wr | input | 1 | Data register write strobe |
| cnt_wdata | input | 8 | Countdown value to load |
| cnt_rdata | output | 8 | Live count |
| flag_clr | input | 1 | Clears the timer flag |
| flag | output | 1 | Sticky timer flag |
| irq | output | 1 | Interrupt output |

## Verification
The bench measures the tick spacing for each of the four source codes. A wrong tap, or a minute counter off by one, would show up as a wrong interval between count changes. It steps a small reload value through a full period to confirm that the count never shows 0 and that the flag rises on the same edge that restores N; a design that expired on reaching 0 would add a tick to the period. It loads zero to catch a design that wraps to 255, writes in consecutive cycles to catch a tick taking priority over a load, and leaves the flag set during a second expiry to catch a pulse mode that only fires on a rising flag. It also checks that the count is frozen while stopped and that irq stays low while its enable is off.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    typedef enum logic [1:0] {
        SRC_FAST = 2'b00,
        SRC_MID  = 2'b01,
        SRC_SLOW = 2'b10,
        SRC_MIN  = 2'b11
    } src_e;

    typedef struct packed {
        logic pulse_mode;
        logic irq_en;
        src_e src;
        logic run;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);
    localparam ctl_t CTL_RESET = '{pulse_mode: 1'b0, irq_en: 1'b0,
                                   src: SRC_MIN, run: 1'b0};

    function automatic logic pick_tick(input logic [3:0] ticks, input src_e src);
        return ticks[src];
    endfunction

endpackage

// File: rtl/cdt_prescaler.sv
module cdt_prescaler #(
    parameter int DIV_FAST  = 3,
    parameter int DIV_MID   = 9,
    parameter int DIV_SLOW  = 15,
    parameter int MIN_TICKS = 60
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_tick,
    output logic [3:0] ticks
);
    localparam int TAPS = 3;
    localparam int SEC_W = (MIN_TICKS > 1) ? $clog2(MIN_TICKS) : 1;
    localparam int TAP_BITS [TAPS] = '{DIV_FAST, DIV_MID, DIV_SLOW};

    logic [DIV_SLOW-1:0] div_q;
    logic [SEC_W-1:0]    sec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else if (ref_tick) begin
            div_q <= div_q + 1'b1;
        end
    end

    for (genvar g = 0; g < TAPS; g++) begin : g_tap
        localparam int NB = TAP_BITS[g];
        assign ticks[g] = ref_tick && (&div_q[NB-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_q <= '0;
        end else if (ticks[2]) begin
            if (sec_q == SEC_W'(MIN_TICKS - 1)) begin
                sec_q <= '0;
            end else begin
                sec_q <= sec_q + 1'b1;
            end
        end
    end

    assign ticks[3] = ticks[2] && (sec_q == SEC_W'(MIN_TICKS - 1));

endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] reload,
    output logic             expire
);
    logic [CNT_W-1:0] count_q, reload_q;
    logic             step;

    assign step   = run && tick && !load && (reload_q != '0);
    assign expire = step && (count_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q  <= '0;
            reload_q <= '0;
        end else if (load) begin
            count_q  <= load_val;
            reload_q <= load_val;
        end else if (expire) begin
            count_q <= reload_q;
        end else if (step) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign count  = count_q;
    assign reload = reload_q;

endmodule

// File: rtl/cdt_irq.sv
module cdt_irq #(
    parameter int PULSE_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic flag_clr,
    input  logic irq_en,
    input  logic pulse_mode,
    output logic flag,
    output logic irq
);
    localparam int PW = $clog2(PULSE_LEN + 1);

    logic          flag_q;
    logic [PW-1:0] pulse_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (expire) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q <= '0;
        end else if (expire) begin
            pulse_q <= PW'(PULSE_LEN);
        end else if (pulse_q != '0) begin
            pulse_q <= pulse_q - 1'b1;
        end
    end

    assign flag = flag_q;
    assign irq  = irq_en && (pulse_mode ? (pulse_q != '0) : flag_q);

endmodule

// File: rtl/cdt_top.sv
module cdt_top
    import cdt_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int DIV_FAST  = 3,
    parameter int DIV_MID   = 9,
    parameter int DIV_SLOW  = 15,
    parameter int MIN_TICKS = 60,
    parameter int PULSE_LEN = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_tick,
    input  logic             ctl_wr,
    input  logic [4:0]       ctl_wdata,
    output logic [4:0]       ctl_rdata,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] cnt_rdata,
    input  logic             flag_clr,
    output logic             flag,
    output logic             irq
);
    ctl_t             ctl_q;
    logic [3:0]       ticks;
    logic             tick_sel;
    logic             expire;
    logic [CNT_W-1:0] reload_val;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= CTL_RESET;
        end else if (ctl_wr) begin
            ctl_q <= ctl_t'(ctl_wdata);
        end
    end

    assign ctl_rdata = ctl_q;
    assign tick_sel  = pick_tick(ticks, ctl_q.src);

    cdt_prescaler #(
        .DIV_FAST(DIV_FAST), .DIV_MID(DIV_MID),
        .DIV_SLOW(DIV_SLOW), .MIN_TICKS(MIN_TICKS)
    ) u_pre (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .ticks(ticks)
    );

    cdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .run(ctl_q.run), .tick(tick_sel),
        .load(cnt_wr), .load_val(cnt_wdata), .count(cnt_rdata),
        .reload(reload_val), .expire(expire)
    );

    cdt_irq #(.PULSE_LEN(PULSE_LEN)) u_irq (
        .clk(clk), .rst(rst), .expire(expire), .flag_clr(flag_clr),
        .irq_en(ctl_q.irq_en), .pulse_mode(ctl_q.pulse_mode),
        .flag(flag), .irq(irq)
    );

endmodule

// File: rtl/cdt_checker.sv
module cdt_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [4:0]       ctl,
    input logic             tick_sel,
    input logic             cnt_wr,
    input logic             flag_clr,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] reload,
    input logic             expire,
    input logic             flag,
    input logic             irq
);
    p_step_down_r4: assert property (@(posedge clk) disable iff (rst)
        (ctl[0] && tick_sel && !cnt_wr && cnt > CNT_W'(1)) |=> (cnt == $past(cnt) - 1'b1));

    p_hold_stopped_r4: assert property (@(posedge clk) disable iff (rst)
        (!ctl[0] && !cnt_wr) |=> $stable(cnt));

    p_never_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (reload != '0) |-> (cnt != '0));

    p_expire_flags_r7: assert property (@(posedge clk) disable iff (rst)
        expire |=> flag);

    p_zero_silent_r6: assert property (@(posedge clk) disable iff (rst)
        (reload == '0) |-> !expire);

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (flag && !flag_clr) |=> flag);

    p_irq_cause_r9: assert property (@(posedge clk) disable iff (rst)
        ($rose(irq) && $stable(ctl)) |-> $past(expire));
endmodule

bind cdt_top cdt_checker #(.CNT_W(CNT_W)) i_chk (
    .clk(clk), .rst(rst), .ctl(ctl_rdata), .tick_sel(tick_sel),
    .cnt_wr(cnt_wr), .flag_clr(flag_clr), .cnt(cnt_rdata),
    .reload(reload_val), .expire(expire), .flag(flag), .irq(irq)
);

// File: tb/test_cdt_top.sv
module test_cdt_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_tick = 1'b1;
    logic       ctl_wr = 1'b0;
    logic [4:0] ctl_wdata = '0;
    logic [4:0] ctl_rdata;
    logic       cnt_wr = 1'b0;
    logic [7:0] cnt_wdata = '0;
    logic [7:0] cnt_rdata;
    logic       flag_clr = 1'b0;
    logic       flag;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cdt_top #(
        .CNT_W(8), .DIV_FAST(1), .DIV_MID(3), .DIV_SLOW(5),
        .MIN_TICKS(3), .PULSE_LEN(4)
    ) i_cdt_top (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .ctl_wr(ctl_wr),
        .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .cnt_wr(cnt_wr),
        .cnt_wdata(cnt_wdata), .cnt_rdata(cnt_rdata), .flag_clr(flag_clr),
        .flag(flag), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_ctl(input logic [4:0] v);
        ctl_wr = 1'b1; ctl_wdata = v; step(); ctl_wr = 1'b0;
    endtask

    task automatic wr_cnt(input logic [7:0] v);
        cnt_wr = 1'b1; cnt_wdata = v; step(); cnt_wr = 1'b0;
    endtask

    task automatic clr_flag();
        flag_clr = 1'b1; step(); flag_clr = 1'b0;
    endtask

    task automatic wait_change(output int n);
        logic [7:0] prev;
        prev = cnt_rdata;
        n = 0;
        do begin
            step();
            n++;
        end while (cnt_rdata == prev && n < 400);
    endtask

    task automatic t_reset();
        chk("R1 ctl", int'(ctl_rdata), 6);
        chk("R1 cnt", int'(cnt_rdata), 0);
        chk("R1 flag", int'(flag), 0);
        chk("R1 irq", int'(irq), 0);
    endtask

    task automatic t_period(input logic [1:0] src, input int exp);
        int n;
        wr_ctl({3'b000, src, 1'b0});
        chk("R2 ctl readback", int'(ctl_rdata), int'({3'b000, src, 1'b0}));
        wr_cnt(8'd200);
        wr_ctl({3'b000, src, 1'b1});
        wait_change(n);
        wait_change(n);
        chk($sformatf("R2 R4 tick spacing src %0d", src), n, exp);
    endtask

    task automatic t_load();
        wr_ctl(5'b00001);
        wr_cnt(8'd200);
        chk("R3 load first", int'(cnt_rdata), 200);
        wr_cnt(8'd150);
        chk("R3 load second phase", int'(cnt_rdata), 150);
    endtask

    task automatic t_expire();
        int n;
        wr_ctl(5'b01000);
        clr_flag();
        wr_cnt(8'd3);
        wr_ctl(5'b01001);
        wait_change(n);
        chk("R5 count 2", int'(cnt_rdata), 2);
        wait_change(n);
        chk("R5 count 1", int'(cnt_rdata), 1);
        chk("R5 no flag yet", int'(flag), 0);
        wait_change(n);
        chk("R5 reload", int'(cnt_rdata), 3);
        chk("R5 flag set", int'(flag), 1);
        chk("R8 irq level", int'(irq), 1);
        repeat (10) step();
        chk("R7 sticky", int'(flag), 1);
        wr_ctl(5'b01000);
        clr_flag();
        chk("R7 cleared", int'(flag), 0);
        chk("R8 irq follows", int'(irq), 0);
    endtask

    task automatic t_pulse();
        int n;
        int w;
        wr_ctl(5'b11000);
        wr_cnt(8'd3);
        wr_ctl(5'b11001);
        w = 0;
        while (!irq && w < 20) begin step(); w++; end
        chk("R9 flag at pulse", int'(flag), 1);
        n = 0;
        while (irq && n < 20) begin step(); n++; end
        chk("R9 pulse length", n, 4);
        w = 0;
        while (!irq && w < 20) begin step(); w++; end
        chk("R9 second pulse with flag set", int'(irq && flag), 1);
        n = 0;
        while (irq && n < 20) begin step(); n++; end
        chk("R9 second pulse length", n, 4);
    endtask

    task automatic t_irq_off();
        int hi = 0;
        wr_ctl(5'b00001);
        repeat (12) begin step(); if (irq) hi++; end
        chk("R10 flag still set", int'(flag), 1);
        chk("R10 irq low", hi, 0);
    endtask

    task automatic t_zero();
        wr_ctl(5'b01000);
        clr_flag();
        wr_cnt(8'd0);
        wr_ctl(5'b01001);
        repeat (30) step();
        chk("R6 count zero", int'(cnt_rdata), 0);
        chk("R6 no flag", int'(flag), 0);
    endtask

    task automatic t_hold();
        logic [7:0] v;
        wr_ctl(5'b00001);
        wr_cnt(8'd100);
        repeat (9) step();
        wr_ctl(5'b00000);
        v = cnt_rdata;
        chk("R4 ran while on", int'(v < 8'd100), 1);
        repeat (40) step();
        chk("R4 hold while off", int'(cnt_rdata), int'(v));
    endtask

    initial begin
        repeat (4) step();
        rst = 1'b0;
        t_reset();
        t_period(2'b00, 2);
        t_period(2'b01, 8);
        t_period(2'b10, 32);
        t_period(2'b11, 96);
        t_load();
        t_expire();
        t_pulse();
        t_irq_off();
        t_zero();
        t_hold();
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected done", cyc);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule